// File: doc/BRIEF.md
# OSD Character Raster Position Generator

This block turns the horizontal and vertical retrace pulses of a monitor into coordinates on a character grid for an on-screen display overlay. It runs on the pixel clock. Every clock it says whether the current pixel falls inside a character cell of the overlay. When it does, it also gives the character row, the character column, the line of the 18-line font to fetch and the dot within the 12-dot cell. These outputs address a display RAM and a font ROM downstream.

The overlay is a grid of 15 rows by 30 columns. Its origin is placed by two coarse start values counted from the retrace edges: 6 pixel clocks per horizontal step and 4 scan lines per vertical step. Each row is stretched to a programmable height of 18 to 63 scan lines by repeating font lines. A programmable gap separates the rows and is split between the top and the bottom of each row. The active level of both retrace inputs is selectable.

Top module: `osd_raster_pos`

## Requirements
- R1: While reset is asserted, and afterwards until the first retrace edge, `in_area` is 0 and all index outputs are 0.
- R2: A horizontal retrace edge is a clock edge at which the input is at its active level after having been inactive at the previous clock edge. The cycle after that edge is dot count 0. Column 0, dot 0 appears at dot count 6*`h_origin`. Holding the input active for longer starts nothing new.
- R3: A row spans 30 columns of 12 dots each. `dot_idx` counts 0 to 11 and then `col_idx` advances, from 0 to 29. After dot 11 of column 29, `in_area` stays low for the rest of the line.
- R4: A vertical retrace edge, detected in the same way, makes the current line number 0. Each later horizontal retrace edge adds one line. Row 0 begins at line 4*`v_origin`.
- R5: Rows repeat with a pitch of gap plus height lines, for 15 rows (0 to 14). After row 14, `in_area` stays low until the next vertical retrace edge.
- R6: Within each pitch, the first floor(`row_gap`/2) lines are blank. Then come the character lines, and the remaining gap lines are blank.
- R7: On character line k of a row (0-based), `font_row` equals floor(k*18/H), where H is the effective height.
- R8: The effective height H is `char_lines`, except that any value below 18 is treated as 18.
- R9: `retrace_act_high` = 0 makes both retrace inputs active low. A value of 1 makes them active high.
- R10: Whenever `in_area` is 0, `row_idx`, `col_idx`, `font_row` and `dot_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_retrace | input | 1 | Horizontal retrace pulse |
| v_retrace | input | 1 | Vertical retrace pulse |
| retrace_act_high | input | 1 | 1: retrace inputs active high, 0: active low |
| h_origin | input | 8 | Horizontal start, in steps of 6 dots |
| v_origin | input | 8 | Vertical start, in steps of 4 lines |
| row_gap | input | 5 | Blank lines between rows, 0 to 31 |
| char_lines | input | 6 | Character height in scan lines, 18 to 63 |
| in_area | output | 1 | Current pixel lies on a character line inside the grid |
| row_idx | output | 4 | Character row, 0 to 14 |
| col_idx | output | 5 | Character column, 0 to 29 |
| font_row | output | 5 | Font line, 0 to 17 |
| dot_idx | output | 4 | Dot within the cell, 0 to 11 |

## Verification
The bench compares every pixel of each driven line against an arithmetic model. It covers a full frame, so the last column and row boundaries and the end of the grid after row 14 are all hit. A design that miscounted these boundaries would show a 31st column or 16th row, or would cut the grid one cell short. Stretched heights of 20 and 27 lines check the repeat pattern of font lines. A wrong accumulator would skip or double the wrong lines, or reach line 18. An odd gap of 5 checks that the top blank share is the rounded-down half. Swapping the shares would shift every character line by one. A height below 18 must behave as 18, and a design that trusted the raw value would start row 1 too early. Active-high retrace with the inputs held for two clocks checks edge detection. A design that reset on level, or on the wrong polarity, would restart mid-pulse or late.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;
    localparam int CELL_DOTS  = 12;
    localparam int FONT_LINES = 18;
    localparam int GRID_COLS  = 30;
    localparam int GRID_ROWS  = 15;
    localparam int H_STEP     = 6;
    localparam int V_STEP     = 4;
    localparam int ORIGIN_W   = 8;
    localparam int GAP_W      = 5;
    localparam int HGT_W      = 6;
endpackage

// File: rtl/osd_retrace_edge.sv
module osd_retrace_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic act_high,
    output logic edge_o
);
    typedef struct packed {
        logic was_act;
    } edge_st_t;

    edge_st_t s_d, s_q;
    logic     act;

    always_comb begin
        act         = act_high ? level_in : ~level_in;
        s_d.was_act = act;
        edge_o      = act & ~s_q.was_act;
    end

    // Reset as "already active" so a pulse held through reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{was_act: 1'b1};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/osd_hpos.sv
module osd_hpos #(
    parameter int CELL_DOTS = osd_raster_pkg::CELL_DOTS,
    parameter int GRID_COLS = osd_raster_pkg::GRID_COLS,
    parameter int H_STEP    = osd_raster_pkg::H_STEP,
    parameter int ORIGIN_W  = osd_raster_pkg::ORIGIN_W,
    localparam int DOT_W    = $clog2(CELL_DOTS),
    localparam int COL_W    = $clog2(GRID_COLS),
    localparam int CNT_W    = $clog2((2**ORIGIN_W - 1) * H_STEP + 2) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic [ORIGIN_W-1:0] h_origin,
    output logic                h_on,
    output logic [COL_W-1:0]    col,
    output logic [DOT_W-1:0]    dot
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             on;
        logic             done;
        logic [COL_W-1:0] col;
        logic [DOT_W-1:0] dot;
    } h_st_t;

    h_st_t            s_d, s_q;
    logic [CNT_W-1:0] origin;

    always_comb begin
        s_d    = s_q;
        origin = CNT_W'(h_origin) * CNT_W'(H_STEP);
        if (line_start) begin
            s_d.cnt  = '0;
            s_d.on   = (origin == '0);
            s_d.done = 1'b0;
            s_d.col  = '0;
            s_d.dot  = '0;
        end else begin
            if (s_q.cnt != '1) s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.on) begin
                if (s_q.dot == DOT_W'(CELL_DOTS - 1)) begin
                    s_d.dot = '0;
                    if (s_q.col == COL_W'(GRID_COLS - 1)) begin
                        s_d.on   = 1'b0;
                        s_d.done = 1'b1;
                        s_d.col  = '0;
                    end else begin
                        s_d.col = s_q.col + COL_W'(1);
                    end
                end else begin
                    s_d.dot = s_q.dot + DOT_W'(1);
                end
            end else if (!s_q.done && (s_q.cnt + CNT_W'(1) == origin)) begin
                s_d.on  = 1'b1;
                s_d.col = '0;
                s_d.dot = '0;
            end
        end
        h_on = s_q.on;
        col  = s_q.col;
        dot  = s_q.dot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, on: 1'b0, done: 1'b1, col: '0, dot: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/osd_vpos.sv
module osd_vpos #(
    parameter int FONT_LINES = osd_raster_pkg::FONT_LINES,
    parameter int GRID_ROWS  = osd_raster_pkg::GRID_ROWS,
    parameter int V_STEP     = osd_raster_pkg::V_STEP,
    parameter int ORIGIN_W   = osd_raster_pkg::ORIGIN_W,
    parameter int GAP_W      = osd_raster_pkg::GAP_W,
    parameter int HGT_W      = osd_raster_pkg::HGT_W,
    localparam int ROW_W     = $clog2(GRID_ROWS),
    localparam int FL_W      = $clog2(FONT_LINES),
    localparam int P_W       = ((GAP_W > HGT_W) ? GAP_W : HGT_W) + 1,
    localparam int CNT_W     = $clog2((2**ORIGIN_W - 1) * V_STEP + 2) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                frame_start,
    input  logic [ORIGIN_W-1:0] v_origin,
    input  logic [GAP_W-1:0]    row_gap,
    input  logic [HGT_W-1:0]    char_lines,
    output logic                v_char,
    output logic [ROW_W-1:0]    row,
    output logic [FL_W-1:0]     font_row
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             on;
        logic             done;
        logic [ROW_W-1:0] row;
        logic [P_W-1:0]   pos;
        logic [FL_W-1:0]  font;
        logic [P_W-1:0]   acc;
    } v_st_t;

    v_st_t            s_d, s_q;
    logic [CNT_W-1:0] origin;
    logic [P_W-1:0]   hgt, top, pitch, acc_sum;

    always_comb begin
        s_d     = s_q;
        origin  = CNT_W'(v_origin) * CNT_W'(V_STEP);
        hgt     = (char_lines < HGT_W'(FONT_LINES)) ? P_W'(FONT_LINES) : P_W'(char_lines);
        top     = P_W'(row_gap >> 1);
        pitch   = P_W'(row_gap) + hgt;
        acc_sum = s_q.acc + P_W'(FONT_LINES);
        if (frame_start) begin
            s_d.cnt  = '0;
            s_d.on   = (origin == '0);
            s_d.done = 1'b0;
            s_d.row  = '0;
            s_d.pos  = '0;
            s_d.font = '0;
            s_d.acc  = '0;
        end else if (line_start) begin
            if (s_q.cnt != '1) s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.on) begin
                if (s_q.pos == pitch - P_W'(1)) begin
                    s_d.pos = '0;
                    if (s_q.row == ROW_W'(GRID_ROWS - 1)) begin
                        s_d.on   = 1'b0;
                        s_d.done = 1'b1;
                        s_d.row  = '0;
                    end else begin
                        s_d.row = s_q.row + ROW_W'(1);
                    end
                end else begin
                    s_d.pos = s_q.pos + P_W'(1);
                end
                // Font line stepping: add 18 per line, take one step per height
                if (s_d.pos == top) begin
                    s_d.font = '0;
                    s_d.acc  = '0;
                end else if (s_d.pos > top && s_d.pos < top + hgt) begin
                    if (acc_sum >= hgt) begin
                        s_d.font = s_q.font + FL_W'(1);
                        s_d.acc  = acc_sum - hgt;
                    end else begin
                        s_d.acc  = acc_sum;
                    end
                end
            end else if (!s_q.done && (s_q.cnt + CNT_W'(1) == origin)) begin
                s_d.on   = 1'b1;
                s_d.row  = '0;
                s_d.pos  = '0;
                s_d.font = '0;
                s_d.acc  = '0;
            end
        end
        v_char   = s_q.on && (s_q.pos >= top) && (s_q.pos < top + hgt);
        row      = s_q.row;
        font_row = s_q.font;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, on: 1'b0, done: 1'b1, row: '0, pos: '0, font: '0, acc: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/osd_raster_pos.sv
module osd_raster_pos
    import osd_raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_retrace,
    input  logic       v_retrace,
    input  logic       retrace_act_high,
    input  logic [7:0] h_origin,
    input  logic [7:0] v_origin,
    input  logic [4:0] row_gap,
    input  logic [5:0] char_lines,
    output logic       in_area,
    output logic [3:0] row_idx,
    output logic [4:0] col_idx,
    output logic [4:0] font_row,
    output logic [3:0] dot_idx
);
    localparam int N_FLY = 2;

    logic [N_FLY-1:0] fly_in, fly_edge;
    logic             h_on, v_char;
    logic [3:0]       row_w, dot_w;
    logic [4:0]       col_w, font_w;

    assign fly_in = {v_retrace, h_retrace};

    for (genvar g = 0; g < N_FLY; g++) begin : g_fly
        osd_retrace_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (fly_in[g]),
            .act_high (retrace_act_high),
            .edge_o   (fly_edge[g])
        );
    end

    osd_hpos #(
        .CELL_DOTS (CELL_DOTS),
        .GRID_COLS (GRID_COLS),
        .H_STEP    (H_STEP),
        .ORIGIN_W  (ORIGIN_W)
    ) u_hpos (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (fly_edge[0]),
        .h_origin   (h_origin),
        .h_on       (h_on),
        .col        (col_w),
        .dot        (dot_w)
    );

    osd_vpos #(
        .FONT_LINES (FONT_LINES),
        .GRID_ROWS  (GRID_ROWS),
        .V_STEP     (V_STEP),
        .ORIGIN_W   (ORIGIN_W),
        .GAP_W      (GAP_W),
        .HGT_W      (HGT_W)
    ) u_vpos (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (fly_edge[0]),
        .frame_start (fly_edge[1]),
        .v_origin    (v_origin),
        .row_gap     (row_gap),
        .char_lines  (char_lines),
        .v_char      (v_char),
        .row         (row_w),
        .font_row    (font_w)
    );

    always_comb begin
        in_area  = h_on & v_char;
        row_idx  = in_area ? row_w  : '0;
        col_idx  = in_area ? col_w  : '0;
        font_row = in_area ? font_w : '0;
        dot_idx  = in_area ? dot_w  : '0;
    end
endmodule

// File: rtl/osd_raster_pos_chk.sv
module osd_raster_pos_chk
    import osd_raster_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       h_retrace,
    input logic       retrace_act_high,
    input logic [7:0] h_origin,
    input logic       in_area,
    input logic [3:0] row_idx,
    input logic [4:0] col_idx,
    input logic [4:0] font_row,
    input logic [3:0] dot_idx
);
    logic h_act;
    assign h_act = retrace_act_high ? h_retrace : ~h_retrace;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_area |-> (row_idx == 4'd0 && col_idx == 5'd0 && font_row == 5'd0 && dot_idx == 4'd0)); // R10
    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_area |-> (dot_idx < 4'(CELL_DOTS))); // R3
    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_area |-> (col_idx < 5'(GRID_COLS))); // R3
    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_area |-> (row_idx < 4'(GRID_ROWS))); // R5
    AST_FONT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_area |-> (font_row < 5'(FONT_LINES))); // R7
    AST_DOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_area && $past(in_area) && $past(dot_idx) != 4'(CELL_DOTS - 1)
         && !($past(h_act) && !$past(h_act, 2)))
        |-> dot_idx == $past(dot_idx) + 4'd1); // R3
    AST_HEDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (h_act && !$past(h_act) && h_origin != 8'd0) |=> !in_area); // R2
endmodule

bind osd_raster_pos osd_raster_pos_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .h_retrace        (h_retrace),
    .retrace_act_high (retrace_act_high),
    .h_origin         (h_origin),
    .in_area          (in_area),
    .row_idx          (row_idx),
    .col_idx          (col_idx),
    .font_row         (font_row),
    .dot_idx          (dot_idx)
);

// File: tb/osd_raster_pos_tb_top.sv
module osd_raster_pos_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 392;
    localparam int WATCHDOG   = 195000;

    logic       clk, rst_n;
    logic       h_retrace, v_retrace, pol;
    logic [7:0] hs, vs;
    logic [4:0] gp;
    logic [5:0] ht;
    logic       in_area;
    logic [3:0] row_idx, dot_idx;
    logic [4:0] col_idx, font_row;

    int n_vec   = 0;
    int n_fail  = 0;
    int n_print = 0;

    osd_raster_pos dut_i (
        .clk (clk), .rst_n (rst_n),
        .h_retrace (h_retrace), .v_retrace (v_retrace), .retrace_act_high (pol),
        .h_origin (hs), .v_origin (vs), .row_gap (gp), .char_lines (ht),
        .in_area (in_area), .row_idx (row_idx), .col_idx (col_idx),
        .font_row (font_row), .dot_idx (dot_idx)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        summary();
        $finish;
    end

    // Independent model of the grid position from dot count x and line l
    task automatic check_pix(input int x, input int l, input string tag);
        int hc, top, pitch, hx, vl, pos;
        logic ea;
        int er, ec, ef, ed;
        hc = (ht < 18) ? 18 : int'(ht);
        top = gp / 2;
        pitch = int'(gp) + hc;
        hx = x - 6 * int'(hs);
        vl = l - 4 * int'(vs);
        ea = 0; er = 0; ec = 0; ef = 0; ed = 0;
        if (hx >= 0 && hx < 360 && vl >= 0 && vl < 15 * pitch) begin
            pos = vl % pitch;
            if (pos >= top && pos < top + hc) begin
                ea = 1;
                er = vl / pitch;
                ec = hx / 12;
                ed = hx % 12;
                ef = (pos - top) * 18 / hc;
            end
        end
        n_vec++;
        if (in_area !== ea || int'(row_idx) != er || int'(col_idx) != ec ||
            int'(font_row) != ef || int'(dot_idx) != ed) begin
            n_fail++;
            if (n_print < 20) begin
                n_print++;
                $display("FAIL %s x=%0d line=%0d act=%b/r%0d/c%0d/f%0d/d%0d exp=%b/r%0d/c%0d/f%0d/d%0d",
                         tag, x, l, in_area, row_idx, col_idx, font_row, dot_idx,
                         ea, er, ec, ef, ed);
            end
        end
    endtask

    task automatic set_cfg(input logic p, input int h, input int v, input int g, input int c);
        @(negedge clk);
        pol = p; hs = 8'(h); vs = 8'(v); gp = 5'(g); ht = 6'(c);
        h_retrace = ~p; v_retrace = ~p;
        repeat (4) @(negedge clk);
    endtask

    // Retrace held active for two clocks: only the first clock is an edge (R2)
    task automatic run_frame(input int nlines, input string tag);
        for (int l = 0; l < nlines; l++) begin
            for (int x = 0; x < LINE_LEN; x++) begin
                @(negedge clk);
                if (x > 0) check_pix(x - 1, l, tag);
                h_retrace = (x < 2) ? pol : ~pol;
                v_retrace = (l == 0 && x < 2) ? pol : ~pol;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pol = 1'b0; hs = 8'd0; vs = 8'd0; gp = 5'd0; ht = 6'd18;
        h_retrace = 1'b1; v_retrace = 1'b1;
        repeat (3) @(negedge clk);
        check_pix(-1, -1, "R1");
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_pix(-1, -1, "R1");   // idle after reset, no retrace yet (R10)
        end
    endtask

    // Whole frame: column and row ends, origin offsets, lines counted by edges
    task automatic t_full_frame();
        set_cfg(1'b0, 2, 1, 0, 18);
        run_frame(4 + 15 * 18 + 2, "R5");   // also R2 R3 R4 R10
    endtask

    task automatic t_stretch();
        set_cfg(1'b0, 0, 0, 0, 27);
        run_frame(32, "R7");
    endtask

    task automatic t_gap();
        set_cfg(1'b0, 1, 2, 5, 20);
        run_frame(40, "R6");
    endtask

    task automatic t_clamp();
        set_cfg(1'b0, 3, 0, 0, 10);
        run_frame(25, "R8");
    endtask

    task automatic t_polarity();
        set_cfg(1'b1, 4, 0, 0, 18);
        run_frame(20, "R9");
    endtask

    initial begin
        t_reset();
        t_full_frame();
        t_stretch();
        t_gap();
        t_clamp();
        t_polarity();
        summary();
        $finish;
    end
endmodule